// File: doc/BRIEF.md
# Daisy-Chain Serial DAC Loader

This block is a host-side controller for a chain of 16-bit serial-input converters that share three wires: a serial data line, a shift clock (wired to each converter's chip-select input, whose rising edge captures one bit), and a shared load strobe that moves each converter's input register into its output register. A host presents one 16-bit word per converter on a flat vector, chooses the bit order, and pulses start. The block then shifts all words out and raises the load strobe once, so that every converter updates at the same moment.

The chain is built so that each converter passes bits on to the next. The word meant for the converter farthest from the controller therefore has to be sent first, and the word for the nearest converter last. The minimum phase lengths of the shift clock, the data setup before a capturing edge, the delay from the last capturing edge to the load strobe, and the load pulse width are all fixed by parameters counted in system-clock cycles. This lets the same logic meet the converters' nanosecond limits at any system clock rate.

Top module: `dac_chain_loader`

## Requirements
- R1: After reset, and whenever the block is idle, the shift clock is high, the load strobe is low, and both busy and done are low.
- R2: A transfer sends NUM_DEV×16 bits, each captured on a rising edge of the shift clock. The word for device NUM_DEV-1 (bits [16*(NUM_DEV-1)+15 : 16*(NUM_DEV-1)] of the word vector) goes first and the word for device 0 (bits [15:0]) goes last.
- R3: With the order select high at start, each word is sent bit 15 first. With it low, each word is sent bit 0 first. The order select and the words are sampled in the cycle that start is accepted.
- R4: Each low phase of the shift clock lasts exactly max(T_LOW, T_SETUP) cycles. The data line changes only in the cycle where the shift clock falls, so it is stable through the whole low phase before a capturing edge and through the high phase after it.
- R5: Between two capturing edges, the shift clock stays high for exactly T_HIGH cycles before it falls again.
- R6: The load strobe rises exactly max(T_HIGH, T_LOAD_DELAY) cycles after the last rising edge of the shift clock, and the shift clock stays high from that edge to the end of the transfer.
- R7: Each transfer produces exactly one load pulse, and it stays high for exactly T_LOAD_W cycles.
- R8: Done is high for exactly one cycle: the first cycle after the load strobe falls. Busy is high from the cycle after start is accepted through the done cycle, and low in the cycle after that.
- R9: A start pulse received while busy is high is ignored. The transfer in progress keeps its data, bit order and bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a transfer |
| msb_first_i | input | 1 | 1: bit 15 of each word first; 0: bit 0 first |
| words_i | input | NUM_DEV*16 | Word for device d at bits [16*d+15 : 16*d]; device 0 is nearest the controller |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse after the load strobe returns low |
| sdata_o | output | 1 | Serial data to the first converter |
| sclk_o | output | 1 | Shift clock to every converter's chip select; rising edge captures |
| load_o | output | 1 | Shared load strobe, active high |

## Verification
Start is accepted at a clock edge, and the shift clock falls in that same cycle. A rising edge follows max(T_LOW, T_SETUP) cycles later, and T_HIGH cycles after each rising edge comes the next falling edge. The load strobe rises max(T_HIGH, T_LOAD_DELAY) cycles after the last rising edge and lasts T_LOAD_W cycles, done follows in the next cycle, and busy drops one cycle after that. The bench samples on the falling system-clock edge and counts run lengths in whole cycles between level changes, so each timing check compares an exact cycle count against these figures. Captured bits are popped from a queue that the driver filled with the expected order, so both order and count are checked at every capturing edge.

// File: rtl/dcl_pkg.sv
// Shared types and helpers for the daisy-chain DAC loader.
// Assumes nothing beyond a single clock domain.
package dcl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_TAIL,
        ST_LOAD,
        ST_DONE
    } dcl_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dcl_phase_timer.sv
// Down-counter that times one phase of the serial protocol.
// Assumes the caller loads (length-1) on entering a phase; expired_o is
// high in the last cycle of that phase.
module dcl_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] value_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    // Count down towards zero; reload on phase entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= value_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/dcl_stream_reg.sv
// Holds the whole chain stream in transmit order and shifts it out.
// Assumes load_i and shift_i are never high together. Bit 0 of the
// register is the bit currently driven on the data line.
module dcl_stream_reg #(
    parameter int NUM_DEV = 3,
    parameter int WORD_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_i,
    input  logic                      shift_i,
    input  logic                      msb_first_i,
    input  logic [NUM_DEV*WORD_W-1:0] words_i,
    output logic                      sdata_o
);
    localparam int TOTAL_BITS = NUM_DEV * WORD_W;

    logic [TOTAL_BITS-1:0] order_msb;
    logic [TOTAL_BITS-1:0] order_lsb;
    logic [TOTAL_BITS-1:0] stream_q;

    // Place each device's word so the farthest device leaves first.
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        for (genvar b = 0; b < WORD_W; b++) begin : g_bit
            localparam int POS = (NUM_DEV - 1 - d) * WORD_W + b;
            assign order_msb[POS] = words_i[d*WORD_W + WORD_W - 1 - b];
            assign order_lsb[POS] = words_i[d*WORD_W + b];
        end
    end

    // Capture the ordered stream at start, shift one bit per clock fall.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stream_q <= '0;
        else if (load_i)
            stream_q <= msb_first_i ? order_msb : order_lsb;
        else if (shift_i)
            stream_q <= {1'b0, stream_q[TOTAL_BITS-1:1]};
    end

    assign sdata_o = stream_q[0];
endmodule

// File: rtl/dac_chain_loader.sv
// Sequencer for a chain of serial-input DACs: shifts NUM_DEV words out
// through a chip-select-style shift clock and issues one shared load pulse.
// Assumes every timing parameter is at least 1 and that the converters'
// order-select level matches msb_first_i.
module dac_chain_loader #(
    parameter int NUM_DEV      = 3,
    parameter int T_SETUP      = 2,
    parameter int T_LOW        = 2,
    parameter int T_HIGH       = 2,
    parameter int T_LOAD_DELAY = 4,
    parameter int T_LOAD_W     = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  msb_first_i,
    input  logic [NUM_DEV*16-1:0] words_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  sdata_o,
    output logic                  sclk_o,
    output logic                  load_o
);
    import dcl_pkg::*;

    localparam int WORD_W     = 16;
    localparam int TOTAL_BITS = NUM_DEV * WORD_W;
    localparam int LOW_LEN    = max2(T_LOW, T_SETUP);
    localparam int TAIL_LEN   = max2(T_HIGH, T_LOAD_DELAY);
    localparam int MAX_LEN    = max2(max2(LOW_LEN, TAIL_LEN), max2(T_HIGH, T_LOAD_W));
    localparam int CNT_W      = $clog2(MAX_LEN + 1);
    localparam int BIT_W      = $clog2(TOTAL_BITS + 1);

    dcl_state_e       st_q, st_nx;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_exp;
    logic             sh_load;
    logic             sh_shift;
    logic [BIT_W-1:0] bits_left_q;

    dcl_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .value_i   (tmr_val),
        .expired_o (tmr_exp)
    );

    dcl_stream_reg #(.NUM_DEV(NUM_DEV), .WORD_W(WORD_W)) u_stream (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (sh_load),
        .shift_i     (sh_shift),
        .msb_first_i (msb_first_i),
        .words_i     (words_i),
        .sdata_o     (sdata_o)
    );

    // Choose the next phase and its length; start is only seen in idle.
    always_comb begin
        st_nx    = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (st_q)
            ST_IDLE: if (start_i) begin
                st_nx    = ST_LOW;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(LOW_LEN - 1);
                sh_load  = 1'b1;
            end
            ST_LOW: if (tmr_exp) begin
                tmr_load = 1'b1;
                if (bits_left_q == '0) begin
                    st_nx   = ST_TAIL;
                    tmr_val = CNT_W'(TAIL_LEN - 1);
                end else begin
                    st_nx   = ST_HIGH;
                    tmr_val = CNT_W'(T_HIGH - 1);
                end
            end
            ST_HIGH: if (tmr_exp) begin
                st_nx    = ST_LOW;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(LOW_LEN - 1);
                sh_shift = 1'b1;
            end
            ST_TAIL: if (tmr_exp) begin
                st_nx    = ST_LOAD;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_LOAD_W - 1);
            end
            ST_LOAD: if (tmr_exp) st_nx = ST_DONE;
            ST_DONE: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    // Bits still to send after the one on the data line.
    always_ff @(posedge clk) begin
        if (!rst_n)        bits_left_q <= '0;
        else if (sh_load)  bits_left_q <= BIT_W'(TOTAL_BITS - 1);
        else if (sh_shift) bits_left_q <= bits_left_q - 1'b1;
    end

    assign sclk_o = (st_q != ST_LOW);
    assign load_o = (st_q == ST_LOAD);
    assign busy_o = (st_q != ST_IDLE);
    assign done_o = (st_q == ST_DONE);
endmodule

// File: rtl/dcl_checker.sv
// Protocol properties of the DAC chain loader, observed at its ports.
// Assumes the parameters passed match the bound instance.
module dcl_checker #(
    parameter int T_HIGH = 2
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic sdata_o,
    input logic sclk_o,
    input logic load_o
);
    logic [15:0] high_run_q;

    // Length of the current busy high phase of the shift clock.
    always_ff @(posedge clk) begin
        if (!rst_n)                high_run_q <= '0;
        else if (sclk_o && busy_o) high_run_q <= high_run_q + 1'b1;
        else                       high_run_q <= '0;
    end

    assert_idle_levels_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (sclk_o && !load_o && !done_o));

    assert_data_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata_o) |-> $fell(sclk_o));

    assert_high_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sclk_o) && $past(busy_o)) |-> (high_run_q == 16'(T_HIGH)));

    assert_load_clk_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> sclk_o);

    assert_done_after_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(load_o) |-> done_o);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> busy_o);
endmodule

bind dac_chain_loader dcl_checker #(.T_HIGH(T_HIGH)) u_dcl_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .sdata_o (sdata_o),
    .sclk_o  (sclk_o),
    .load_o  (load_o)
);

// File: tb/dac_chain_loader_bench.sv
// Scoreboard bench: the driver queues expected bits, the monitor checks
// every capturing edge and every phase length at the ports.
module dac_chain_loader_bench;
    localparam int NDEV   = 3;
    localparam int TL     = 2;
    localparam int TS     = 4;
    localparam int TH     = 3;
    localparam int TD     = 5;
    localparam int TW     = 2;
    localparam int LOWL   = (TL > TS) ? TL : TS;
    localparam int TAILL  = (TH > TD) ? TH : TD;
    localparam int NBITS  = NDEV * 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic msb = 1'b1;
    logic [NDEV*16-1:0] words = '0;
    logic busy, done, sdata, sclk, load;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 0;
    bit exp_q[$];

    always #10 clk = ~clk;

    dac_chain_loader #(
        .NUM_DEV(NDEV), .T_SETUP(TS), .T_LOW(TL), .T_HIGH(TH),
        .T_LOAD_DELAY(TD), .T_LOAD_W(TW)
    ) u_dac_chain_loader (
        .clk(clk), .rst_n(rst_n), .start_i(start), .msb_first_i(msb),
        .words_i(words), .busy_o(busy), .done_o(done), .sdata_o(sdata),
        .sclk_o(sclk), .load_o(load)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor state.
    logic p_sclk = 1'b1, p_load = 1'b0, p_sdata = 1'b0;
    int low_run = 0, high_run = 0, since_rise = 0, load_run = 0;
    int rises = 0, loads = 0;
    bit idle_next = 0;

    // Sample away from the active edge and compare against the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            since_rise++;
            if (idle_next) begin
                chk(!busy && !done && sclk && !load, "R8 busy/done low after done", busy, 0);
                idle_next = 0;
            end
            if (p_sclk && !sclk) begin
                if (rises > 0) chk(high_run == TH, "R5 high phase", high_run, TH);
                low_run = 1;
            end else if (!p_sclk && !sclk) begin
                low_run++;
                chk(sdata == p_sdata, "R4 data stable in low phase", sdata, p_sdata);
            end else if (!p_sclk && sclk) begin
                chk(low_run == LOWL, "R4 low phase", low_run, LOWL);
                if (exp_q.size() == 0) begin
                    chk(0, "R2 extra capturing edge", rises + 1, NBITS);
                end else begin
                    automatic bit e = exp_q.pop_front();
                    chk(sdata == e, "R2/R3 captured bit", sdata, e);
                end
                rises++;
                high_run = 1;
                since_rise = 0;
            end else begin
                if (busy) begin
                    high_run++;
                    chk(sdata == p_sdata, "R4 data held in high phase", sdata, p_sdata);
                end
            end
            if (load && !p_load) begin
                chk(since_rise == TAILL, "R6 load delay", since_rise, TAILL);
                chk(sclk, "R6 clock high at load", sclk, 1);
                loads++;
                load_run = 1;
            end else if (load) begin
                load_run++;
            end else if (p_load) begin
                chk(load_run == TW, "R7 load width", load_run, TW);
                chk(done, "R8 done after load", done, 1);
                chk(busy, "R8 busy through done", busy, 1);
                chk(rises == NBITS, "R2 bit count", rises, NBITS);
                chk(loads == 1, "R7 single load", loads, 1);
                chk(exp_q.size() == 0, "R9 all expected bits sent", exp_q.size(), 0);
                idle_next = 1;
            end
            p_sclk = sclk; p_load = load; p_sdata = sdata;
        end
    end

    // Queue the expected stream, start, optionally inject a start while busy.
    task automatic run_xfer(input logic [NDEV*16-1:0] w, input logic m, input int inject);
        for (int d = NDEV - 1; d >= 0; d--)
            for (int b = 0; b < 16; b++)
                exp_q.push_back(m ? w[d*16 + 15 - b] : w[d*16 + b]);
        rises = 0; loads = 0;
        @(negedge clk);
        words = w; msb = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R8 busy after start", busy, 1);
        chk(!sclk, "R4 clock falls at start", sclk, 0);
        if (inject > 0) begin
            repeat (inject) @(negedge clk);
            words = ~w; msb = ~m; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy, "R9 still busy after ignored start", busy, 1);
        end
        while (!done) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Hung-run guard.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sclk && !load && !busy && !done, "R1 reset levels", {sclk, load, busy, done}, 4'b1000);
        run_xfer(48'hA5C3_1234_F00F, 1'b1, 0);
        run_xfer(48'h8001_7FFE_00FF, 1'b0, 0);
        run_xfer(48'hFFFF_0000_5555, 1'b1, 20);
        run_xfer(48'h0001_8000_C0DE, 1'b0, 60);
        chk(sclk && !load && !busy && !done, "R1 idle levels", {sclk, load, busy, done}, 4'b1000);
        repeat (5) @(negedge clk);
        chk(sclk && !load && !busy, "R1 idle without start", {sclk, load, busy}, 3'b100);
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule